// File: doc/BRIEF.md
# Register-Mapped Multiply, Accumulate and Divide Engine

This block is an arithmetic peripheral that sits on a small synchronous register bus next to a 16-bit processor core. Software loads two 16-bit operand halves and receives an unsigned 32-bit product. In accumulate mode, the same product is added into a 32-bit running sum. In divide mode, the block runs an unsigned 32-by-32 division over several clocks. One set of operand registers serves three roles: it holds the multiplier inputs, it holds the dividend, and it receives the quotient.

The bus has seven word locations. Index 0 and 1 are operand A low and high. Index 2 and 3 are operand B low and high. Index 4 and 5 are sum C low and high. Index 6 is the 8-bit control register, placed in the low byte. Index 7 reads as zero. Reads are combinational from the address. Writes take effect at the clock edge on which `wr_en` is high, with one byte-enable bit per 8-bit lane.

Three control bits matter. Bit 7 selects divide mode. Bit 6 selects accumulate mode, or masks the completion interrupt when bit 7 is set. Bit 0 starts a division and reads back as the busy flag. A division takes 16 clocks. At the end it writes the quotient into A and the remainder into C, and may raise a one-cycle interrupt pulse.

Top module: `mdu_top`

## Requirements
- R1: After reset every register reads 0 and `irq` is low.
- R2: When control bits 7 and 6 are both 0, a write to operand A high (index 1) loads the product A_low * A_high into B high:low. The new value is readable one cycle after the write edge.
- R3: When control bit 6 is set and bit 7 is clear, a write to A high also adds the same product into C high:low. The sum is readable two cycles after the write edge, and the old sum is still visible one cycle after it.
- R4: The 32-bit sum wraps modulo 2^32.
- R5: A control write with bits 7 and 0 both set starts a division. Control bit 0 then reads 1 for exactly 16 cycles and 0 afterwards.
- R6: When a division ends, A high:low holds the quotient of (A high:low) / (B high:low), taken at the start. C high:low holds the remainder.
- R7: With a zero divisor, the division takes the same 16 cycles. It yields an all-ones quotient and a remainder equal to the dividend.
- R8: While a division runs, bus writes to every register, including the control register, have no effect.
- R9: When control bit 7 is set and bit 6 is clear, `irq` pulses high for one cycle, in the cycle where bit 0 first reads 0. With bit 6 set, `irq` stays low.
- R10: `byte_en[0]` writes bits 7:0 and `byte_en[1]` writes bits 15:8. A lane that is not enabled keeps its old value.
- R11: A control write with bit 0 set but bit 7 clear does not start a division. Bit 0 reads 0 and the operands stay unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the addressed register |
| addr | input | 3 | Register index 0..7 |
| wdata | input | 16 | Write data |
| byte_en | input | 2 | Byte-lane write enables |
| rdata | output | 16 | Read data for `addr` |
| irq | output | 1 | One-cycle division-complete pulse |

## Verification
The bench builds the block with its default parameters: 16-bit halves and two quotient bits resolved per clock. With these values the 16-cycle divide latency can be counted exactly, and the full-range operands can be reached, such as 0xFFFF squared and an all-ones dividend. Directed cases cover both sides of the one-cycle gap between a plain product and a running sum, sum wrap-around, the zero divisor, and bus writes that land in the middle of a division.

// File: rtl/mdu_pkg.sv
package mdu_pkg;

    // Register indices on the bus
    localparam int unsigned REG_A_LO  = 0;
    localparam int unsigned REG_A_HI  = 1;
    localparam int unsigned REG_B_LO  = 2;
    localparam int unsigned REG_B_HI  = 3;
    localparam int unsigned REG_C_LO  = 4;
    localparam int unsigned REG_C_HI  = 5;
    localparam int unsigned REG_CTRL  = 6;
    localparam int unsigned NUM_DATA  = 6;

    // Control bit positions
    localparam int unsigned CTRL_DIV_BIT   = 7;
    localparam int unsigned CTRL_MAC_BIT   = 6;
    localparam int unsigned CTRL_START_BIT = 0;

    typedef enum logic [1:0] {
        MODE_MUL = 2'd0,
        MODE_MAC = 2'd1,
        MODE_DIV = 2'd2
    } mdu_mode_e;

    function automatic mdu_mode_e ctrl_mode(input logic [7:0] c);
        if (c[CTRL_DIV_BIT])      return MODE_DIV;
        else if (c[CTRL_MAC_BIT]) return MODE_MAC;
        else                      return MODE_MUL;
    endfunction

endpackage

// File: rtl/mdu_div_core.sv
module mdu_div_core #(
    parameter int OP_W  = 32,
    parameter int STEPS = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  logic [OP_W-1:0] dividend,
    input  logic [OP_W-1:0] divisor,
    output logic            busy,
    output logic            done,
    output logic [OP_W-1:0] quotient,
    output logic [OP_W-1:0] remainder
);
    localparam int CYCLES = OP_W / STEPS;
    localparam int CNT_W  = (CYCLES > 1) ? $clog2(CYCLES) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(CYCLES - 1);

    logic             busy_q;
    logic [CNT_W-1:0] cnt_q;
    logic [OP_W-1:0]  rem_q;
    logic [OP_W-1:0]  quo_q;
    logic [OP_W-1:0]  dvs_q;

    // Combinational chain of restoring steps resolved in one clock
    logic [OP_W-1:0] rem_c [0:STEPS];
    logic [OP_W-1:0] quo_c [0:STEPS];

    assign rem_c[0] = rem_q;
    assign quo_c[0] = quo_q;

    for (genvar i = 0; i < STEPS; i++) begin : g_step
        logic [OP_W:0] shifted;
        logic          fits;
        always_comb begin
            shifted = {rem_c[i], quo_c[i][OP_W-1]};
            fits    = (shifted >= {1'b0, dvs_q});
        end
        logic [OP_W:0] diff;
        assign diff         = shifted - {1'b0, dvs_q};
        assign rem_c[i+1]   = fits ? diff[OP_W-1:0] : shifted[OP_W-1:0];
        assign quo_c[i+1]   = {quo_c[i][OP_W-2:0], fits};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
            rem_q  <= '0;
            quo_q  <= '0;
            dvs_q  <= '0;
        end else if (!busy_q) begin
            if (start) begin
                busy_q <= 1'b1;
                cnt_q  <= '0;
                rem_q  <= '0;
                quo_q  <= dividend;
                dvs_q  <= divisor;
            end
        end else begin
            rem_q <= rem_c[STEPS];
            quo_q <= quo_c[STEPS];
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == LAST) begin
                busy_q <= 1'b0;
            end
        end
    end

    assign busy      = busy_q;
    assign done      = busy_q && (cnt_q == LAST);
    assign quotient  = quo_c[STEPS];
    assign remainder = rem_c[STEPS];

endmodule

// File: rtl/mdu_mul_path.sv
module mdu_mul_path #(
    parameter int HALF_W = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                trig,
    input  logic                mac_sel,
    input  logic [HALF_W-1:0]   a_lo,
    input  logic [HALF_W-1:0]   a_hi,
    input  logic [2*HALF_W-1:0] acc_cur,
    output logic                b_wr,
    output logic [2*HALF_W-1:0] prod,
    output logic                acc_wr,
    output logic [2*HALF_W-1:0] acc_next
);
    localparam int FULL_W = 2 * HALF_W;

    logic              pend_q;
    logic              pend_mac_q;
    logic              acc_v_q;
    logic [FULL_W-1:0] prod_q;

    // Operands already hold the written value one cycle after the trigger
    assign prod = {{HALF_W{1'b0}}, a_lo} * {{HALF_W{1'b0}}, a_hi};

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q     <= 1'b0;
            pend_mac_q <= 1'b0;
            acc_v_q    <= 1'b0;
            prod_q     <= '0;
        end else begin
            pend_q     <= trig;
            pend_mac_q <= trig && mac_sel;
            acc_v_q    <= pend_q && pend_mac_q;
            if (pend_q) begin
                prod_q <= prod;
            end
        end
    end

    assign b_wr     = pend_q;
    assign acc_wr   = acc_v_q;
    assign acc_next = acc_cur + prod_q;

endmodule

// File: rtl/mdu_regs.sv
module mdu_regs
    import mdu_pkg::*;
#(
    parameter int HALF_W = 16,
    parameter int ADDR_W = 3
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [HALF_W-1:0]   wdata,
    input  logic [HALF_W/8-1:0] byte_en,
    output logic [HALF_W-1:0]   rdata,
    input  logic                div_busy,
    input  logic                div_done,
    input  logic [2*HALF_W-1:0] quo_in,
    input  logic [2*HALF_W-1:0] rem_in,
    input  logic                b_wr,
    input  logic [2*HALF_W-1:0] prod_in,
    input  logic                acc_wr,
    input  logic [2*HALF_W-1:0] acc_in,
    output logic [HALF_W-1:0]   a_lo,
    output logic [HALF_W-1:0]   a_hi,
    output logic [HALF_W-1:0]   b_lo,
    output logic [HALF_W-1:0]   b_hi,
    output logic [HALF_W-1:0]   c_lo,
    output logic [HALF_W-1:0]   c_hi,
    output logic [7:0]          ctrl_q,
    output logic                mul_trig,
    output logic                mac_sel,
    output logic                div_start
);
    localparam int LANES = HALF_W / 8;

    logic [HALF_W-1:0] data_q [NUM_DATA];
    logic [6:0]        ctrl_hi_q;
    logic              bus_ok;
    logic              ctrl_hit;
    mdu_mode_e         mode;

    function automatic logic [HALF_W-1:0] merge_lanes(
        input logic [HALF_W-1:0] old_v,
        input logic [HALF_W-1:0] new_v,
        input logic [LANES-1:0]  be
    );
        logic [HALF_W-1:0] r;
        r = old_v;
        for (int l = 0; l < LANES; l++) begin
            if (be[l]) r[l*8 +: 8] = new_v[l*8 +: 8];
        end
        return r;
    endfunction

    assign ctrl_q   = {ctrl_hi_q, div_busy};
    assign mode     = ctrl_mode(ctrl_q);
    assign bus_ok   = wr_en && !div_busy;
    assign ctrl_hit = bus_ok && (addr == ADDR_W'(REG_CTRL)) && byte_en[0];

    assign mul_trig  = bus_ok && (addr == ADDR_W'(REG_A_HI)) && (|byte_en) && (mode != MODE_DIV);
    assign mac_sel   = (mode == MODE_MAC);
    assign div_start = ctrl_hit && wdata[CTRL_DIV_BIT] && wdata[CTRL_START_BIT];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < NUM_DATA; k++) data_q[k] <= '0;
            ctrl_hi_q <= '0;
        end else begin
            for (int k = 0; k < NUM_DATA; k++) begin
                if (bus_ok && (addr == ADDR_W'(k))) begin
                    data_q[k] <= merge_lanes(data_q[k], wdata, byte_en);
                end
            end
            if (ctrl_hit) begin
                ctrl_hi_q <= wdata[7:1];
            end
            // Engine updates take priority over bus writes
            if (b_wr) begin
                data_q[REG_B_LO] <= prod_in[HALF_W-1:0];
                data_q[REG_B_HI] <= prod_in[2*HALF_W-1:HALF_W];
            end
            if (acc_wr) begin
                data_q[REG_C_LO] <= acc_in[HALF_W-1:0];
                data_q[REG_C_HI] <= acc_in[2*HALF_W-1:HALF_W];
            end
            if (div_done) begin
                data_q[REG_A_LO] <= quo_in[HALF_W-1:0];
                data_q[REG_A_HI] <= quo_in[2*HALF_W-1:HALF_W];
                data_q[REG_C_LO] <= rem_in[HALF_W-1:0];
                data_q[REG_C_HI] <= rem_in[2*HALF_W-1:HALF_W];
            end
        end
    end

    always_comb begin
        rdata = '0;
        if (addr == ADDR_W'(REG_CTRL)) begin
            rdata = {{(HALF_W-8){1'b0}}, ctrl_q};
        end else begin
            for (int k = 0; k < NUM_DATA; k++) begin
                if (addr == ADDR_W'(k)) rdata = data_q[k];
            end
        end
    end

    assign a_lo = data_q[REG_A_LO];
    assign a_hi = data_q[REG_A_HI];
    assign b_lo = data_q[REG_B_LO];
    assign b_hi = data_q[REG_B_HI];
    assign c_lo = data_q[REG_C_LO];
    assign c_hi = data_q[REG_C_HI];

endmodule

// File: rtl/mdu_top.sv
module mdu_top
    import mdu_pkg::*;
#(
    parameter int HALF_W    = 16,
    parameter int DIV_STEPS = 2,
    parameter int ADDR_W    = 3
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [HALF_W-1:0]   wdata,
    input  logic [HALF_W/8-1:0] byte_en,
    output logic [HALF_W-1:0]   rdata,
    output logic                irq
);
    localparam int FULL_W     = 2 * HALF_W;
    localparam int DIV_CYCLES = FULL_W / DIV_STEPS;

    logic [HALF_W-1:0] a_lo, a_hi, b_lo, b_hi, c_lo, c_hi;
    logic [7:0]        ctrl_q;
    logic              mul_trig, mac_sel, div_start;
    logic              div_busy, div_done;
    logic [FULL_W-1:0] quo, rem;
    logic              b_wr, acc_wr;
    logic [FULL_W-1:0] prod, acc_next;
    logic              irq_q;

    mdu_regs #(.HALF_W(HALF_W), .ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .addr      (addr),
        .wdata     (wdata),
        .byte_en   (byte_en),
        .rdata     (rdata),
        .div_busy  (div_busy),
        .div_done  (div_done),
        .quo_in    (quo),
        .rem_in    (rem),
        .b_wr      (b_wr),
        .prod_in   (prod),
        .acc_wr    (acc_wr),
        .acc_in    (acc_next),
        .a_lo      (a_lo),
        .a_hi      (a_hi),
        .b_lo      (b_lo),
        .b_hi      (b_hi),
        .c_lo      (c_lo),
        .c_hi      (c_hi),
        .ctrl_q    (ctrl_q),
        .mul_trig  (mul_trig),
        .mac_sel   (mac_sel),
        .div_start (div_start)
    );

    mdu_mul_path #(.HALF_W(HALF_W)) u_mul (
        .clk      (clk),
        .rst      (rst),
        .trig     (mul_trig),
        .mac_sel  (mac_sel),
        .a_lo     (a_lo),
        .a_hi     (a_hi),
        .acc_cur  ({c_hi, c_lo}),
        .b_wr     (b_wr),
        .prod     (prod),
        .acc_wr   (acc_wr),
        .acc_next (acc_next)
    );

    mdu_div_core #(.OP_W(FULL_W), .STEPS(DIV_STEPS)) u_div (
        .clk       (clk),
        .rst       (rst),
        .start     (div_start),
        .dividend  ({a_hi, a_lo}),
        .divisor   ({b_hi, b_lo}),
        .busy      (div_busy),
        .done      (div_done),
        .quotient  (quo),
        .remainder (rem)
    );

    always_ff @(posedge clk) begin
        if (rst) irq_q <= 1'b0;
        else     irq_q <= div_done && ctrl_q[CTRL_DIV_BIT] && !ctrl_q[CTRL_MAC_BIT];
    end

    assign irq = irq_q;

endmodule

// File: rtl/mdu_checker.sv
module mdu_checker #(
    parameter int HALF_W = 16,
    parameter int ADDR_W = 3,
    parameter int CYCLES = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic              wd_div,
    input logic              wd_start,
    input logic              be0,
    input logic              irq,
    input logic              div_busy,
    input logic              ctrl_div,
    input logic              ctrl_mac,
    input logic [HALF_W-1:0] a_lo
);
    localparam int CW = $clog2(CYCLES + 2);

    logic [CW-1:0] busy_len;
    logic          ctrl_wr_idle;

    always_ff @(posedge clk) begin
        if (rst)           busy_len <= '0;
        else if (div_busy) busy_len <= busy_len + 1'b1;
        else               busy_len <= '0;
    end

    assign ctrl_wr_idle = wr_en && !div_busy && (addr == ADDR_W'(6)) && be0;

    // R5
    start_chk: assert property (@(posedge clk) disable iff (rst)
        (ctrl_wr_idle && wd_div && wd_start) |=> div_busy);

    // R5
    busy_len_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(div_busy) |-> (busy_len == CW'(CYCLES)));

    // R8
    busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (div_busy && wr_en && (addr == ADDR_W'(0))) |=> (!div_busy || $stable(a_lo)));

    // R9
    irq_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        irq |=> !irq);

    // R9
    irq_src_chk: assert property (@(posedge clk) disable iff (rst)
        irq |-> ($past(div_busy) && !div_busy && ctrl_div && !ctrl_mac));

    // R11
    no_start_chk: assert property (@(posedge clk) disable iff (rst)
        (ctrl_wr_idle && !wd_div) |=> !div_busy);

endmodule

bind mdu_top mdu_checker #(
    .HALF_W (HALF_W),
    .ADDR_W (ADDR_W),
    .CYCLES (DIV_CYCLES)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .addr     (addr),
    .wd_div   (wdata[7]),
    .wd_start (wdata[0]),
    .be0      (byte_en[0]),
    .irq      (irq),
    .div_busy (div_busy),
    .ctrl_div (ctrl_q[7]),
    .ctrl_mac (ctrl_q[6]),
    .a_lo     (a_lo)
);

// File: tb/tb_mdu_top.sv
module tb_mdu_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [2:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic [1:0]  byte_en = '0;
    logic [15:0] rdata;
    logic        irq;

    int total = 0;
    int bad   = 0;

    always #10 clk = ~clk;

    mdu_top dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .byte_en(byte_en), .rdata(rdata), .irq(irq)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // Drive at a falling edge, commit at the next rising edge, return at the falling edge after
    task automatic wr(input logic [2:0] a, input logic [15:0] d, input logic [1:0] be);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d; byte_en = be;
        @(negedge clk);
        wr_en = 1'b0; byte_en = '0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic rd32(input logic [2:0] lo, output logic [31:0] d);
        logic [15:0] l, h;
        rd(lo, l);
        rd(lo + 3'd1, h);
        d = {h, l};
    endtask

    task automatic t_reset;
        logic [15:0] v;
        for (int k = 0; k < 7; k++) begin
            rd(3'(k), v);
            check("R1 reset reg", {16'h0, v}, 32'h0);
        end
        check("R1 reset irq", {31'h0, irq}, 32'h0);
    endtask

    task automatic t_mul(input logic [15:0] x, input logic [15:0] y);
        logic [31:0] v;
        wr(3'd6, 16'h0000, 2'b01);
        wr(3'd0, x, 2'b11);
        wr(3'd1, y, 2'b11);
        @(negedge clk);
        rd32(3'd2, v);
        check("R2 product", v, {16'h0, x} * {16'h0, y});
    endtask

    task automatic t_mac;
        logic [31:0] v;
        wr(3'd6, 16'h0040, 2'b01);
        wr(3'd4, 16'h0000, 2'b11);
        wr(3'd5, 16'h0000, 2'b11);
        wr(3'd0, 16'd3, 2'b11);
        wr(3'd1, 16'd5, 2'b11);
        @(negedge clk);
        rd32(3'd4, v);
        check("R3 sum not yet updated", v, 32'd0);
        rd32(3'd2, v);
        check("R3 product also in B", v, 32'd15);
        @(negedge clk);
        rd32(3'd4, v);
        check("R3 sum after extra cycle", v, 32'd15);
        wr(3'd0, 16'd4, 2'b11);
        wr(3'd1, 16'd6, 2'b11);
        repeat (2) @(negedge clk);
        rd32(3'd4, v);
        check("R3 second accumulate", v, 32'd39);
        // wrap-around
        wr(3'd4, 16'hFFFF, 2'b11);
        wr(3'd5, 16'hFFFF, 2'b11);
        wr(3'd0, 16'd1, 2'b11);
        wr(3'd1, 16'd2, 2'b11);
        repeat (2) @(negedge clk);
        rd32(3'd4, v);
        check("R4 sum wraps", v, 32'd1);
    endtask

    task automatic t_div(input logic [31:0] dd, input logic [31:0] ds,
                         input logic mask, input string tag);
        logic [31:0] v, eq, er;
        logic [15:0] c;
        int n;
        eq = (ds == 0) ? 32'hFFFF_FFFF : dd / ds;
        er = (ds == 0) ? dd : dd % ds;
        wr(3'd6, mask ? 16'h00C0 : 16'h0080, 2'b01);
        wr(3'd0, dd[15:0], 2'b11);
        wr(3'd1, dd[31:16], 2'b11);
        wr(3'd2, ds[15:0], 2'b11);
        wr(3'd3, ds[31:16], 2'b11);
        wr(3'd6, mask ? 16'h00C1 : 16'h0081, 2'b01);
        n = 0;
        rd(3'd6, c);
        while (c[0] && n < 100) begin
            check("R9 no irq while busy", {31'h0, irq}, 32'h0);
            n++;
            @(negedge clk);
            rd(3'd6, c);
        end
        check({"R5 busy cycles ", tag}, n, 32'd16);
        check({"R9 irq at completion ", tag}, {31'h0, irq}, {31'h0, !mask});
        rd32(3'd0, v);
        check({"R6 quotient ", tag}, v, eq);
        rd32(3'd4, v);
        check({"R6 remainder ", tag}, v, er);
        @(negedge clk);
        check({"R9 irq one cycle ", tag}, {31'h0, irq}, 32'h0);
    endtask

    task automatic t_div_zero;
        logic [31:0] v;
        t_div(32'h1234_5678, 32'h0, 1'b0, "zero divisor");
        rd32(3'd0, v);
        check("R7 all-ones quotient", v, 32'hFFFF_FFFF);
        rd32(3'd4, v);
        check("R7 remainder equals dividend", v, 32'h1234_5678);
    endtask

    task automatic t_busy_writes;
        logic [31:0] v;
        logic [15:0] c;
        int n;
        wr(3'd6, 16'h00C0, 2'b01);
        wr(3'd0, 16'd1000, 2'b11);
        wr(3'd1, 16'd0, 2'b11);
        wr(3'd2, 16'd8, 2'b11);
        wr(3'd3, 16'd0, 2'b11);
        wr(3'd6, 16'h00C1, 2'b01);
        wr(3'd0, 16'hFFFF, 2'b11);
        wr(3'd2, 16'h0001, 2'b11);
        wr(3'd4, 16'h5555, 2'b11);
        wr(3'd6, 16'h0000, 2'b01);
        n = 0;
        rd(3'd6, c);
        while (c[0] && n < 100) begin
            n++;
            @(negedge clk);
            rd(3'd6, c);
        end
        rd32(3'd0, v);
        check("R8 quotient unaffected", v, 32'd125);
        rd32(3'd4, v);
        check("R8 remainder unaffected", v, 32'd0);
        rd32(3'd2, v);
        check("R8 divisor kept", v, 32'd8);
        check("R8 control write ignored", {16'h0, c}, 32'h00C0);
    endtask

    task automatic t_bytes;
        logic [15:0] v;
        wr(3'd6, 16'h0080, 2'b01);
        wr(3'd0, 16'h1122, 2'b11);
        wr(3'd0, 16'hAB55, 2'b10);
        rd(3'd0, v);
        check("R10 upper lane only", {16'h0, v}, 32'hAB22);
        wr(3'd0, 16'h77CC, 2'b01);
        rd(3'd0, v);
        check("R10 lower lane only", {16'h0, v}, 32'hABCC);
    endtask

    task automatic t_no_start;
        logic [15:0] v;
        wr(3'd6, 16'h0000, 2'b01);
        wr(3'd0, 16'h4321, 2'b11);
        wr(3'd6, 16'h0001, 2'b01);
        rd(3'd6, v);
        check("R11 start bit ignored", {16'h0, v}, 32'h0);
        repeat (20) @(negedge clk);
        rd(3'd0, v);
        check("R11 operand unchanged", {16'h0, v}, 32'h4321);
        check("R11 no irq", {31'h0, irq}, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_mul(16'h1234, 16'h5678);
        t_mul(16'hFFFF, 16'hFFFF);
        t_mul(16'h0000, 16'hBEEF);
        t_mac();
        t_div(32'd100, 32'd7, 1'b0, "small");
        t_div(32'hDEAD_BEEF, 32'h10, 1'b1, "masked");
        t_div(32'd5, 32'd10, 1'b0, "divisor larger");
        t_div(32'hFFFF_FFFF, 32'h1, 1'b0, "all ones");
        t_div_zero();
        t_busy_writes();
        t_bytes();
        t_no_start();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule